// File: doc/BRIEF.md
# Vector-Driven FIFO Word Unpacker

This block sits on the transmit side of a serial engine, between the transmit FIFO and the bit serialiser. It takes 32-bit FIFO entries through a valid/ready handshake. It cuts each entry into a short run of chunks, one to eight bits each, and hands them downstream one at a time.

Where each chunk comes from is set at run time by four 10-bit packing vectors, held in two 32-bit configuration words. A vector gives a start bit, a read direction, a width, and a stop marker. Each chunk leaves the block right-aligned in an 8-bit field. It carries its bit count and a flag on the final chunk of its entry. Software can therefore describe several layouts with no change to the hardware: four small words per entry, two half-words, or one wide word cut MSB-first or LSB-first.

The vectors are captured together with the entry. A configuration write that lands mid-entry takes effect only from the next entry.

Top module: `fifo_chunk_unpacker`

## Requirements
- R1: While reset is asserted and right after it, `chunkValid` is 0 and `entryReady` is 1.
- R2: An entry is taken only while no chunk is pending: `entryReady` is 0 whenever `chunkValid` is 1, and an entry offered while busy stays waiting.
- R3: Vector k (k = 0..3) is read from bits `[10*(k%2)+9 : 10*(k%2)]`, taken from `cfgLo` for k < 2 and from `cfgHi` otherwise. Inside a vector, bits 9:5 give the start index, bit 4 the direction, bits 3:1 the width minus one, and bit 0 the stop marker. An accepted entry starts at vector 0.
- R4: `chunkBits` equals the width field plus one, so it always lies in 1..8.
- R5: With direction 0, output bit j (j below the width) is entry bit start+j. The bits are read upward from the start index.
- R6: With direction 1, the chunk is read downward from the start index, most significant bit first. Output bit width-1-j is entry bit start-j.
- R7: Output bits at or above `chunkBits` are 0. A picked position outside 0..31 also gives 0.
- R8: The vector whose stop marker is set yields the last chunk of the entry, with `chunkLast` = 1. Once that chunk is taken, `entryReady` returns to 1 on the next cycle.
- R9: If no vector up to vector 3 has its stop marker set, the sequence still ends at vector 3, which is flagged last. Non-final chunks step through the vectors in increasing order.
- R10: The configuration words are sampled when an entry is accepted. Changing them later does not alter that entry's chunks.
- R11: While `chunkValid` is 1 and `chunkReady` is 0, the chunk data, bit count and last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLo | input | 32 | Packing vectors 0 and 1 |
| cfgHi | input | 32 | Packing vectors 2 and 3 |
| entryData | input | 32 | FIFO entry to be unpacked |
| entryValid | input | 1 | Entry offered |
| entryReady | output | 1 | Block can take an entry |
| chunkData | output | 8 | Current chunk, right-aligned |
| chunkBits | output | 4 | Number of valid bits in the chunk (1..8) |
| chunkLast | output | 1 | Chunk is the last of its entry |
| chunkValid | output | 1 | Chunk offered downstream |
| chunkReady | input | 1 | Downstream takes the chunk |

## Verification
A wrong vector pointer or a stale captured vector shows on the very next chunk offered. It appears as a wrong value, a wrong bit count, or a last flag that comes early or never comes. A sequencer stuck busy shows as `entryReady` staying low after the stop chunk, one cycle after the handshake. Comparing every chunk against an independently built expectation, under both steady and random back-pressure, therefore exposes such faults within one entry. Scrambling the configuration right after each acceptance exposes any path that reads the live registers instead of the captured ones.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int ENTRY_W     = 32;
  localparam int CHUNK_MAX   = 8;
  localparam int CFG_W       = 32;
  localparam int START_W     = $clog2(ENTRY_W);
  localparam int LEN_W       = $clog2(CHUNK_MAX);
  localparam int VEC_W       = START_W + LEN_W + 2;
  localparam int VEC_PER_CFG = 2;

  // Field order inside a vector, MSB to LSB: start, direction, width-1, stop.
  typedef struct packed {
    logic [START_W-1:0] startIdx;
    logic               readDown;
    logic [LEN_W-1:0]   lenM1;
    logic               stopHere;
  } packVec_t;

  // Strobes from sequencer to datapath.
  typedef struct packed {
    logic load;  // capture entry and vector bank, select vector 0
    logic step;  // move to the next vector of the bank
  } seqStrobe_t;
endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
#(
  parameter int NUM_VEC = 4,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             entryValid,
  output logic             entryReady,
  input  logic             chunkReady,
  output logic             chunkValid,
  output logic             chunkLast,
  input  logic             curStop,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] vecIdx
);
  logic             busyQ;
  logic [IDX_W-1:0] vecIdxQ;
  logic             atEnd;
  logic             fire;

  assign atEnd      = curStop || (vecIdxQ == IDX_W'(NUM_VEC - 1));
  assign fire       = busyQ && chunkReady;
  assign entryReady = !busyQ;
  assign chunkValid = busyQ;
  assign chunkLast  = busyQ && atEnd;
  assign vecIdx     = vecIdxQ;

  always_comb begin
    strobe      = '0;
    strobe.load = entryValid && !busyQ;
    strobe.step = fire && !atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      vecIdxQ <= '0;
    end else if (strobe.load) begin
      busyQ   <= 1'b1;
      vecIdxQ <= '0;
    end else if (strobe.step) begin
      vecIdxQ <= vecIdxQ + 1'b1;
    end else if (fire) begin
      busyQ <= 1'b0;
    end
  end

  // R3: an accepted entry starts at vector 0
  p_accept_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    entryValid && entryReady |=> chunkValid && (vecIdx == '0));

  // R8: taking the last chunk frees the block
  p_last_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkReady && chunkLast |=> entryReady && !chunkValid);

  // R9: a non-final chunk advances to the next vector
  p_step_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkReady && !chunkLast |=> chunkValid && (vecIdx == $past(vecIdx) + 1'b1));

  // R11: back-pressure freezes the sequence
  p_hold_seq_r11: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && !chunkReady |=> chunkValid && $stable(vecIdx) && $stable(chunkLast));
endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int NUM_VEC = 4,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [IDX_W-1:0]     vecIdx,
  input  packVec_t             vecIn [NUM_VEC],
  input  logic [ENTRY_W-1:0]   entryData,
  output logic [CHUNK_MAX-1:0] chunkData,
  output logic [LEN_W:0]       chunkBits,
  output logic                 curStop
);
  logic [ENTRY_W-1:0]   entryQ;
  packVec_t             vecBankQ [NUM_VEC];
  packVec_t             curVecQ;
  logic [IDX_W-1:0]     nextIdx;
  logic [CHUNK_MAX-1:0] pickBit;

  assign nextIdx = vecIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryQ  <= '0;
      curVecQ <= '0;
      for (int k = 0; k < NUM_VEC; k++) vecBankQ[k] <= '0;
    end else if (strobe.load) begin
      entryQ  <= entryData;
      curVecQ <= vecIn[0];
      for (int k = 0; k < NUM_VEC; k++) vecBankQ[k] <= vecIn[k];
    end else if (strobe.step) begin
      curVecQ <= vecBankQ[nextIdx];
    end
  end

  // One selector per output bit; the read direction picks the source index.
  for (genvar j = 0; j < CHUNK_MAX; j++) begin : g_bit
    logic bitJ;
    int   pos;
    always_comb begin
      if (curVecQ.readDown)
        pos = int'(curVecQ.startIdx) - int'(curVecQ.lenM1) + j;
      else
        pos = int'(curVecQ.startIdx) + j;
      bitJ = 1'b0;
      if ((j <= int'(curVecQ.lenM1)) && (pos >= 0) && (pos < ENTRY_W))
        bitJ = entryQ[pos[START_W-1:0]];
    end
    assign pickBit[j] = bitJ;
  end

  assign chunkData = pickBit;
  assign chunkBits = (LEN_W+1)'(curVecQ.lenM1) + (LEN_W+1)'(1);
  assign curStop   = curVecQ.stopHere;

  // R4: bit count stays within 1..CHUNK_MAX
  p_bits_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chunkBits >= 1) && (int'(chunkBits) <= CHUNK_MAX));

  // R7: nothing above the bit count
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chunkData >> chunkBits) == '0);

  // R10: the first vector comes from the configuration at acceptance
  p_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> curVecQ == $past(vecIn[0]));

  // R11: no strobe, no change in the offered chunk
  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.step |=> $stable(chunkData) && $stable(chunkBits));
endmodule

// File: rtl/fifo_chunk_unpacker.sv
module fifo_chunk_unpacker
  import unpack_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CFG_W-1:0]     cfgLo,
  input  logic [CFG_W-1:0]     cfgHi,
  input  logic [ENTRY_W-1:0]   entryData,
  input  logic                 entryValid,
  output logic                 entryReady,
  output logic [CHUNK_MAX-1:0] chunkData,
  output logic [LEN_W:0]       chunkBits,
  output logic                 chunkLast,
  output logic                 chunkValid,
  input  logic                 chunkReady
);
  localparam int IDX_W = $clog2(NUM_VEC);

  packVec_t         vecIn [NUM_VEC];
  seqStrobe_t       strobe;
  logic [IDX_W-1:0] vecIdx;
  logic             curStop;

  // Vector k lives in word k/VEC_PER_CFG at slot k%VEC_PER_CFG.
  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
    localparam int WORD = k / VEC_PER_CFG;
    localparam int LSB  = (k % VEC_PER_CFG) * VEC_W;
    if (WORD == 0) begin : g_lo
      assign vecIn[k] = packVec_t'(cfgLo[LSB +: VEC_W]);
    end else begin : g_hi
      assign vecIn[k] = packVec_t'(cfgHi[LSB +: VEC_W]);
    end
  end

  unpack_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .entryValid (entryValid),
    .entryReady (entryReady),
    .chunkReady (chunkReady),
    .chunkValid (chunkValid),
    .chunkLast  (chunkLast),
    .curStop    (curStop),
    .strobe     (strobe),
    .vecIdx     (vecIdx)
  );

  unpack_datapath #(.NUM_VEC(NUM_VEC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vecIdx    (vecIdx),
    .vecIn     (vecIn),
    .entryData (entryData),
    .chunkData (chunkData),
    .chunkBits (chunkBits),
    .curStop   (curStop)
  );
endmodule

// File: tb/sim_fifo_chunk_unpacker.sv
`timescale 1ns/1ps
module sim_fifo_chunk_unpacker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgLo = '0, cfgHi = '0, entryData = '0;
  logic        entryValid = 1'b0, chunkReady = 1'b0;
  logic        entryReady, chunkLast, chunkValid;
  logic [7:0]  chunkData;
  logic [3:0]  chunkBits;

  typedef struct {
    logic [7:0] data;
    logic [3:0] bits;
    logic       last;
    string      tag;
    string      lastTag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0, fails = 0;
  bit          randReady = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  fifo_chunk_unpacker u0 (
    .clk(clk), .rstN(rstN), .cfgLo(cfgLo), .cfgHi(cfgHi),
    .entryData(entryData), .entryValid(entryValid), .entryReady(entryReady),
    .chunkData(chunkData), .chunkBits(chunkBits), .chunkLast(chunkLast),
    .chunkValid(chunkValid), .chunkReady(chunkReady)
  );

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Vector fields per R3: start 9:5, direction 4, width-1 3:1, stop 0
  function automatic logic [9:0] mkVec(int st, int dn, int lm1, int sp);
    return 10'((st << 5) | (dn << 4) | (lm1 << 1) | sp);
  endfunction

  // Expected chunks built from the requirements
  task automatic expectEntry(logic [31:0] lo, logic [31:0] hi, logic [31:0] e,
                             string tag, string lastTag);
    for (int k = 0; k < 4; k++) begin
      logic [9:0] v;
      int st, dn, w;
      exp_t it;
      v  = (k < 2) ? lo[k*10 +: 10] : hi[(k-2)*10 +: 10];
      st = int'(v[9:5]);
      dn = int'(v[4]);
      w  = int'(v[3:1]) + 1;
      it.data = '0;
      for (int j = 0; j < w; j++) begin
        int p;
        logic b;
        p = dn ? st - j : st + j;
        b = (p >= 0 && p < 32) ? e[p] : 1'b0;
        if (dn) it.data[w-1-j] = b;
        else    it.data[j]     = b;
      end
      it.bits    = 4'(w);
      it.last    = v[0] || (k == 3);
      it.tag     = tag;
      it.lastTag = lastTag;
      q.push_back(it);
      if (it.last) break;
    end
  endtask

  // Driver: offer an entry, wait for acceptance, then scramble the inputs (R10)
  task automatic sendEntry(logic [31:0] lo, logic [31:0] hi, logic [31:0] e,
                           string tag, string lastTag);
    @(negedge clk);
    cfgLo = lo; cfgHi = hi; entryData = e; entryValid = 1'b1;
    #0.5;
    while (!entryReady) begin
      @(negedge clk);
      #0.5;
    end
    expectEntry(lo, hi, e, tag, lastTag);
    @(negedge clk);
    entryValid = 1'b0;
    cfgLo = ~lo; cfgHi = ~hi; entryData = ~e;
  endtask

  // Monitor: pop and compare at every downstream handshake
  initial begin
    bit         holdArm = 1'b0;
    logic [7:0] hData;
    logic [3:0] hBits;
    logic       hLast;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      chunkReady = randReady ? lfsr[0] : 1'b1;
      #0.5;
      if (holdArm) begin
        check(chunkValid && chunkData == hData && chunkBits == hBits && chunkLast == hLast,
              "R11", "held chunk", {chunkBits, chunkData}, {hBits, hData});
        holdArm = 1'b0;
      end
      if (chunkValid && !chunkReady) begin
        holdArm = 1'b1;
        hData = chunkData; hBits = chunkBits; hLast = chunkLast;
      end
      if (chunkValid && chunkReady) begin
        exp_t it;
        check(!entryReady, "R2", "entryReady while chunk pending", 32'(entryReady), 0);
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected chunk", 32'(chunkData), 0);
        end else begin
          it = q.pop_front();
          check(chunkData == it.data, it.tag, "chunk data", 32'(chunkData), 32'(it.data));
          check(chunkBits == it.bits, "R4", "chunk bits", 32'(chunkBits), 32'(it.bits));
          check(chunkLast == it.last, it.lastTag, "last flag", 32'(chunkLast), 32'(it.last));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] lo, hi;
    repeat (3) @(negedge clk);
    #0.5;
    check(!chunkValid, "R1", "chunkValid in reset", 32'(chunkValid), 0);
    check(entryReady, "R1", "entryReady in reset", 32'(entryReady), 1);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    check(!chunkValid && entryReady, "R1", "idle after reset",
          {30'd0, chunkValid, entryReady}, 32'd1);

    // Four 7-bit words, MSB first (R3, R6)
    lo = {12'd0, mkVec(14, 1, 6, 0), mkVec(6, 1, 6, 0)};
    hi = {12'd0, mkVec(30, 1, 6, 1), mkVec(22, 1, 6, 0)};
    sendEntry(lo, hi, 32'hA5C3_7E19, "R3", "R8");
    sendEntry(lo, hi, 32'h5F0A_81E7, "R6", "R8");

    // Two 15-bit words, LSB first (R5)
    lo = {12'd0, mkVec(8, 0, 6, 0), mkVec(0, 0, 7, 0)};
    hi = {12'd0, mkVec(24, 0, 6, 1), mkVec(16, 0, 7, 0)};
    sendEntry(lo, hi, 32'h1234_ABCD, "R5", "R8");

    // One 23-bit word MSB first, stop on vector 2 (R8)
    lo = {12'd0, mkVec(14, 1, 7, 0), mkVec(22, 1, 7, 0)};
    hi = {12'd0, mkVec(0, 1, 0, 0), mkVec(6, 1, 6, 1)};
    sendEntry(lo, hi, 32'h00F3_5A96, "R6", "R8");

    // No stop marker anywhere: ends at vector 3 (R9)
    lo = {12'd0, mkVec(8, 0, 7, 0), mkVec(0, 0, 7, 0)};
    hi = {12'd0, mkVec(24, 0, 7, 0), mkVec(16, 0, 7, 0)};
    sendEntry(lo, hi, 32'hDEAD_BEEF, "R5", "R9");

    // Picks running past either end of the entry (R7)
    lo = {12'd0, mkVec(2, 1, 7, 0), mkVec(30, 0, 7, 0)};
    hi = {12'd0, mkVec(5, 0, 3, 1), mkVec(31, 1, 0, 0)};
    sendEntry(lo, hi, 32'hFFFF_FFFF, "R7", "R8");

    // Back-to-back entries with scrambled configuration in between (R10)
    sendEntry(lo, hi, 32'h8000_0001, "R10", "R8");
    sendEntry(lo, hi, 32'h7FFF_FFFE, "R10", "R8");

    // Random vectors and entries under random back-pressure (R11)
    randReady = 1'b1;
    for (int n = 0; n < 60; n++) begin
      sendEntry($urandom, $urandom, $urandom, "R11", "R9");
    end
    randReady = 1'b0;

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #0.5;
    check(entryReady && !chunkValid, "R8", "idle after final chunk",
          {30'd0, chunkValid, entryReady}, 32'd1);
    summary();
    $finish;
  end
endmodule